// File: doc/BRIEF.md
# Early/Late Phase Detector with Phase-Code Stepper

This block steers an external clock delay line so that a divided clock derived from the memory channel lines up with a divided clock derived from the controller. Both divided clocks are brought into a fast oversampling clock domain. On each rising edge of the channel-side divided clock, the block checks whether the controller-side clock is already high. If it is, the channel side is late. If it is not, the channel side is early. No phase magnitude is measured. The phase code then moves by exactly one step in the direction that reduces the error.

The detection window is half a period of the divided clocks on either side of alignment, which gives the correction range of plus or minus half an input period. Updates are paced only by the channel-side clock. If that clock stops, or if both inputs are tied low in a system that does not use phase alignment, the code holds its value. Updating resumes as soon as the channel-side clock toggles again.

A lock flag rises after a programmable number of consecutive direction reversals, which is the dithering pattern of a converged early/late loop. A powerdown input clears the lock flag and freezes the code. The code, last direction and update strobe are plain level outputs sampled by the delay line. There is no handshake and no back-pressure: the delay line must accept every update in the cycle it is presented.

Top module: `bbpd_phase_ctrl`

## Requirements
- R1: Each divided-clock input passes through two flip-flops clocked by `clk` before edge detection. A rising edge on `fb_div_i` set up before clock edge k updates `code_o` at edge k+2: the third rising `clk` edge seen by the input.
- R2: At each channel-side rising edge, if the synchronized `ref_div_i` is 1, the update is a step down (`dir_o` = 0, code minus 1). If it is 0, the update is a step up (`dir_o` = 1, code plus 1). The code never moves by more than one per update.
- R3: The code saturates. A step up at the all-ones value and a step down at 0 leave it unchanged.
- R4: When `fb_div_i` is static (including both inputs held at 0), `code_o` holds its value. Updating resumes on the next rising edge of `fb_div_i`.
- R5: While `rst_n` is 0, `code_o` is the mid value 2^(CODE_W-1), and `lock_o`, `upd_o` and `dir_o` are 0.
- R6: While `pwr_off_i` is 1, `lock_o` is 0 from the next cycle and channel edges cause no update. After release, lock must be earned again from zero reversals.
- R7: The first update after reset or powerdown counts no reversal. Each later update opposite to the previous one adds a reversal, and an update in the same direction resets the count to 0. `lock_o` is 1 exactly while the count is at least `lock_len_i`, with a setting of 0 treated as 1. `lock_o` changes together with `code_o`.
- R8: `upd_o` is a one-cycle pulse in the cycle `code_o` takes its updated value, including at saturation. `dir_o` holds the direction of the last update.
- R9: Edges on `ref_div_i` alone never cause an update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_off_i | input | 1 | Powerdown: freezes code, clears lock (synchronous to clk) |
| ref_div_i | input | 1 | Controller-side divided clock |
| fb_div_i | input | 1 | Channel-side divided clock, paces updates |
| lock_len_i | input | LOCK_W | Reversals needed to declare lock (0 acts as 1) |
| code_o | output | CODE_W | Phase-delay code for the external delay line |
| dir_o | output | 1 | Direction of the last update, 1 = later |
| upd_o | output | 1 | One-cycle strobe with each update |
| lock_o | output | 1 | Lock indicator |

## Verification
The assertions assume that `pwr_off_i` and `lock_len_i` are synchronous to `clk`. They also assume that each level of `fb_div_i` lasts at least two oversampling cycles, so that no channel edge is merged or lost in the synchronizer. The stimulus changes every input on the falling edge of `clk`. It holds each divided-clock level for four cycles, and it raises the controller-side clock one cycle before the channel-side edge whenever a step down is intended.

// File: rtl/bbpd_pkg.sv
package bbpd_pkg;
  typedef enum logic {
    STEP_DN = 1'b0,
    STEP_UP = 1'b1
  } step_dir_e;
endpackage

// File: rtl/bbpd_sync.sv
module bbpd_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  // R1: two flops per asynchronous input
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/bbpd_decide.sv
module bbpd_decide
  import bbpd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      fb_s_i,
  input  logic      ref_s_i,
  input  logic      hold_i,
  output logic      step_o,
  output step_dir_e dir_o
);
  logic fb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fb_q <= 1'b0;
    else        fb_q <= fb_s_i;
  end

  // R2: early/late only; controller side already high means channel is late
  assign step_o = fb_s_i & ~fb_q & ~hold_i;
  assign dir_o  = ref_s_i ? STEP_DN : STEP_UP;

  // R8: a channel rising edge yields at most one step
  a_r8_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |=> !step_o);

  // R6: no step while powered down
  a_r6_no_step_off: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |-> !step_o);
endmodule

// File: rtl/bbpd_code_step.sv
module bbpd_code_step
  import bbpd_pkg::*;
#(
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  step_dir_e         dir_i,
  output logic [CODE_W-1:0] code_o,
  output logic              upd_o,
  output logic              dir_o
);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;
  localparam logic [CODE_W-1:0] CODE_MIN = '0;
  localparam logic [CODE_W-1:0] CODE_MID = {1'b1, {(CODE_W-1){1'b0}}};

  logic [CODE_W-1:0] code_n;

  always_comb begin
    code_n = code_o;
    if (step_i) begin
      if (dir_i == STEP_UP) begin
        if (code_o != CODE_MAX) code_n = code_o + 1'b1;
      end else begin
        if (code_o != CODE_MIN) code_n = code_o - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_o <= CODE_MID;
      upd_o  <= 1'b0;
      dir_o  <= 1'b0;
    end else begin
      code_o <= code_n;
      upd_o  <= step_i;
      if (step_i) dir_o <= dir_i;
    end
  end

  // R3: saturation at both ends
  a_r3_sat_top: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && dir_i == STEP_UP && code_o == CODE_MAX) |=> code_o == CODE_MAX);
  a_r3_sat_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && dir_i == STEP_DN && code_o == CODE_MIN) |=> code_o == CODE_MIN);

  // R4: without a step the code is frozen
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(code_o));

  // R2: one step at most per update
  a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> (code_o == $past(code_o) || code_o == $past(code_o) + 1'b1 ||
                code_o == $past(code_o) - 1'b1));
endmodule

// File: rtl/bbpd_lock_det.sv
module bbpd_lock_det
  import bbpd_pkg::*;
#(
  parameter int LOCK_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              step_i,
  input  step_dir_e         dir_i,
  input  logic [LOCK_W-1:0] len_i,
  output logic              lock_o
);
  localparam logic [LOCK_W-1:0] CNT_MAX = '1;

  logic [LOCK_W-1:0] rev_cnt, rev_cnt_n, thr;
  logic              prev_v;
  step_dir_e         prev_dir;

  assign thr = (len_i == '0) ? LOCK_W'(1) : len_i;

  // R7: count consecutive direction reversals
  always_comb begin
    if (prev_v && dir_i != prev_dir)
      rev_cnt_n = (rev_cnt == CNT_MAX) ? rev_cnt : rev_cnt + 1'b1;
    else
      rev_cnt_n = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rev_cnt  <= '0;
      prev_v   <= 1'b0;
      prev_dir <= STEP_DN;
      lock_o   <= 1'b0;
    end else if (clr_i) begin
      rev_cnt  <= '0;
      prev_v   <= 1'b0;
      prev_dir <= STEP_DN;
      lock_o   <= 1'b0;
    end else if (step_i) begin
      rev_cnt  <= rev_cnt_n;
      prev_v   <= 1'b1;
      prev_dir <= dir_i;
      lock_o   <= (rev_cnt_n >= thr);
    end
  end

  // R6: powerdown drops lock
  a_r6_lock_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !lock_o);

  // R7: repeated direction breaks lock
  a_r7_same_dir_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !clr_i && prev_v && dir_i == prev_dir) |=> !lock_o);

  // R7: lock only changes on an update
  a_r7_lock_on_step: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> $past(step_i));
endmodule

// File: rtl/bbpd_phase_ctrl.sv
module bbpd_phase_ctrl
  import bbpd_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int LOCK_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_off_i,
  input  logic              ref_div_i,
  input  logic              fb_div_i,
  input  logic [LOCK_W-1:0] lock_len_i,
  output logic [CODE_W-1:0] code_o,
  output logic              dir_o,
  output logic              upd_o,
  output logic              lock_o
);
  logic [1:0] sync_q;
  logic       step;
  step_dir_e  step_dir;

  bbpd_sync #(.W(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({ref_div_i, fb_div_i}),
    .q_o   (sync_q)
  );

  bbpd_decide u_decide (
    .clk     (clk),
    .rst_n   (rst_n),
    .fb_s_i  (sync_q[0]),
    .ref_s_i (sync_q[1]),
    .hold_i  (pwr_off_i),
    .step_o  (step),
    .dir_o   (step_dir)
  );

  bbpd_code_step #(.CODE_W(CODE_W)) u_code (
    .clk    (clk),
    .rst_n  (rst_n),
    .step_i (step),
    .dir_i  (step_dir),
    .code_o (code_o),
    .upd_o  (upd_o),
    .dir_o  (dir_o)
  );

  bbpd_lock_det #(.LOCK_W(LOCK_W)) u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (pwr_off_i),
    .step_i (step),
    .dir_i  (step_dir),
    .len_i  (lock_len_i),
    .lock_o (lock_o)
  );

  // R8: strobe and lock changes line up with code changes
  a_r8_code_moves_on_upd: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_o) |-> upd_o);

  // R9: a static channel clock after sync produces no strobe
  a_r9_no_upd_static_fb: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_o && $stable(sync_q[0])) |=> !upd_o);
endmodule

// File: tb/bbpd_phase_ctrl_tb.sv
module bbpd_phase_ctrl_tb;
  localparam int CW = 4;
  localparam int LW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pwr_off = 1'b0;
  logic          ref_div = 1'b0;
  logic          fb_div = 1'b0;
  logic [LW-1:0] lock_len = 4'd3;
  logic [CW-1:0] code;
  logic          dir, upd, lock;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bbpd_phase_ctrl #(.CODE_W(CW), .LOCK_W(LW)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_off_i  (pwr_off),
    .ref_div_i  (ref_div),
    .fb_div_i   (fb_div),
    .lock_len_i (lock_len),
    .code_o     (code),
    .dir_o      (dir),
    .upd_o      (upd),
    .lock_o     (lock)
  );

  // vector: {ref level at channel edge, expected code, expected lock}, lock_len = 3
  localparam logic [5:0] VEC [8] = '{
    {1'b0, 4'd9, 1'b0},
    {1'b1, 4'd8, 1'b0},
    {1'b0, 4'd9, 1'b0},
    {1'b1, 4'd8, 1'b1},
    {1'b1, 4'd7, 1'b0},
    {1'b0, 4'd8, 1'b0},
    {1'b0, 4'd9, 1'b0},
    {1'b1, 4'd8, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_period(input logic r);
    @(negedge clk) ref_div = r;
    @(negedge clk) fb_div = 1'b1;
    repeat (4) @(negedge clk);
    fb_div = 1'b0;
    ref_div = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R5 code in reset", code, 8);
    chk("R5 lock in reset", lock, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R5 code", code, 8);
    chk("R5 lock", lock, 0);
    chk("R5 upd", upd, 0);
    chk("R5 dir", dir, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 latency and R8 strobe
    fb_div = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 no update before third edge", code, 8);
    chk("R1 no strobe before third edge", upd, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R1 update at third edge", code, 9);
    chk("R8 strobe with update", upd, 1);
    chk("R2 dir up when ref low", dir, 1);
    @(negedge clk);
    chk("R8 strobe lasts one cycle", upd, 0);
    fb_div = 1'b0;
    repeat (4) @(negedge clk);

    do_reset();

    // R2/R7 table
    for (int i = 0; i < 8; i++) begin
      run_period(VEC[i][5]);
      chk($sformatf("R2 code vec %0d", i), code, VEC[i][4:1]);
      chk($sformatf("R7 lock vec %0d", i), lock, VEC[i][0]);
      chk($sformatf("R2 dir vec %0d", i), dir, !VEC[i][5]);
    end

    // R9 controller edges alone
    for (int i = 0; i < 10; i++) begin
      @(negedge clk) ref_div = 1'b1;
      repeat (3) @(negedge clk);
      ref_div = 1'b0;
      repeat (3) @(negedge clk);
    end
    chk("R9 code after ref-only edges", code, 8);
    chk("R9 no strobe", upd, 0);

    // R4 grounded inputs, then resume
    repeat (40) @(negedge clk);
    chk("R4 code static with grounded inputs", code, 8);
    run_period(1'b0);
    chk("R4 update resumes", code, 9);

    // R3 saturation
    for (int i = 0; i < 10; i++) run_period(1'b0);
    chk("R3 saturate top", code, 15);
    chk("R7 no lock while pushing one way", lock, 0);
    for (int i = 0; i < 20; i++) run_period(1'b1);
    chk("R3 saturate bottom", code, 0);
    run_period(1'b1);
    chk("R3 stays at bottom", code, 0);

    // R6 powerdown
    run_period(1'b0);
    run_period(1'b1);
    run_period(1'b0);
    chk("R7 lock after three reversals", lock, 1);
    chk("R7 code at lock", code, 1);
    @(negedge clk) pwr_off = 1'b1;
    repeat (2) @(negedge clk);
    chk("R6 lock cleared", lock, 0);
    run_period(1'b0);
    run_period(1'b0);
    chk("R6 code frozen", code, 1);
    @(negedge clk) pwr_off = 1'b0;
    run_period(1'b1);
    run_period(1'b0);
    chk("R6 lock re-earned from zero", lock, 0);
    chk("R6 code moves after release", code, 1);

    // R7 threshold 0 acts as 1
    do_reset();
    lock_len = '0;
    run_period(1'b0);
    chk("R7 len0 first update no lock", lock, 0);
    run_period(1'b1);
    chk("R7 len0 lock after one reversal", lock, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule